// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler

This block turns the system clock into the timing events an I2C master needs to drive SCL. Two divider stages run in series. The first stage counts out (M+1) system clocks. The second stage counts a power of two of those first-stage wraps. Each wrap of the second stage is one sub-tick, and ten sub-ticks make one SCL period. A ten-phase sequencer steps on every sub-tick. It holds SCL low for five sub-ticks and high for five. It emits one-cycle strobes when SCL rises, when SCL falls, and at the sampling point in the middle of the high half.

Software loads M and N with a single write word. An exponent-mode input chooses the length of the second stage: either 2^(N+1) sub-stage wraps (the normal setting) or 2^N wraps. While the controller is idle, the dividers are held cleared and SCL is parked high. When `run` rises, the first edge therefore comes after full-length timing. While the bus is running, new settings are held back until the end of the current SCL period.

Top module: `i2c_rate_prescaler`

## Requirements
- R1: A write with `cfg_we` high loads N from `cfg_wdata[2:0]` and M from `cfg_wdata[6:3]` into a pending copy.
- R2: With `exp_mode` low, one sub-tick lasts (M+1)·2^(N+1) system clocks, so the SCL period is ten times that.
- R3: With `exp_mode` high, one sub-tick lasts (M+1)·2^N system clocks, so the SCL period is ten times that.
- R4: Within each SCL period SCL is low for five sub-ticks and high for five. `scl_rise` pulses five sub-ticks after `scl_fall`.
- R5: `sample_pt` pulses two sub-ticks after `scl_rise`, which marks the start of the middle high sub-tick.
- R6: Pending M, N and `exp_mode` are applied only where one SCL period ends and the next begins, or at any time while idle. The period in progress always completes with its old timing.
- R7: While `run` is low, `scl_out` is high, no strobe fires and the counters stay cleared. After `run` rises, the first `scl_fall` comes after five full sub-ticks.
- R8: After reset, M and N are 0, `scl_out` is high and all strobes are low.
- R9: `soft_rst` returns the pending and applied M and N to 0 and parks the sequencer. They stay 0 until they are written again.
- R10: Each strobe lasts one clock cycle, and no two strobes are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of settings and sequencer |
| cfg_we | input | 1 | Write strobe for the rate word |
| cfg_wdata | input | 7 | Rate word: M in [6:3], N in [2:0] |
| exp_mode | input | 1 | 1: second stage is 2^N; 0: second stage is 2^(N+1) |
| run | input | 1 | Controller active; low holds the dividers cleared |
| sub_tick | output | 1 | One-cycle pulse at each tenth of an SCL period |
| scl_out | output | 1 | SCL level to drive (1 = released high) |
| scl_rise | output | 1 | Pulse in the first cycle that SCL is high |
| scl_fall | output | 1 | Pulse in the first cycle that SCL is low |
| sample_pt | output | 1 | Pulse at the data sampling point |

## Verification
A corrupted first-stage or second-stage count shows up as a wrong distance between `scl_fall` strobes in the very next SCL period. A settings register applied at the wrong moment shows up as a period of mixed length, measured from the fall right after the write. A sequencer phase that is off by one moves `scl_rise` or `sample_pt` by a whole sub-tick within a single period. If idle is handled wrongly, the first fall after `run` rises arrives at the wrong cycle count.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

  // Number of first-stage wraps that make one sub-tick.
  function automatic int stage2_span(int n, logic exp_short);
    return exp_short ? (1 << n) : (1 << (n + 1));
  endfunction

  // System clocks in one sub-tick.
  function automatic int subtick_cycles(int m, int n, logic exp_short);
    return (m + 1) * stage2_span(n, exp_short);
  endfunction

endpackage

// File: rtl/rate_cfg_reg.sv
module rate_cfg_reg #(
  parameter int M_W = 4,
  parameter int N_W = 3,
  localparam int WORD_W = M_W + N_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              exp_mode,
  input  logic              run,
  input  logic              boundary,
  output logic [M_W-1:0]    m_act,
  output logic [N_W-1:0]    n_act,
  output logic              exp_act
);

  logic [M_W-1:0] m_pend;
  logic [N_W-1:0] n_pend;
  logic           apply_now;

  assign apply_now = !run || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0;
      n_pend <= '0;
    end else if (soft_rst) begin
      m_pend <= '0;
      n_pend <= '0;
    end else if (wr_en) begin
      m_pend <= wr_data[WORD_W-1:N_W];
      n_pend <= wr_data[N_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act   <= '0;
      n_act   <= '0;
      exp_act <= 1'b0;
    end else if (soft_rst) begin
      m_act   <= '0;
      n_act   <= '0;
      exp_act <= 1'b0;
    end else if (apply_now) begin
      m_act   <= m_pend;
      n_act   <= n_pend;
      exp_act <= exp_mode;
    end
  end

  // R6: applied settings hold still through a running period
  assert_hold_midperiod_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary && !soft_rst) |=> ($stable(m_act) && $stable(n_act) && $stable(exp_act)));

  // R9: a soft reset leaves the applied fields at zero
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (m_act == '0 && n_act == '0));

endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import i2c_rate_pkg::*;
#(
  parameter int M_W = 4,
  parameter int N_W = 3,
  localparam int C2_W = 1 << N_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic [M_W-1:0] m_act,
  input  logic [N_W-1:0] n_act,
  input  logic           exp_act,
  output logic           sub_tick
);

  logic [M_W-1:0]  c1;
  logic [C2_W-1:0] c2;
  logic [C2_W-1:0] c2_lim;
  logic            c1_wrap;
  logic            c2_wrap;

  assign c2_lim   = C2_W'(stage2_span(int'(n_act), exp_act) - 1);
  assign c1_wrap  = (c1 == m_act);
  assign c2_wrap  = (c2 == c2_lim);
  assign sub_tick = !clear && c1_wrap && c2_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0;
      c2 <= '0;
    end else if (clear) begin
      c1 <= '0;
      c2 <= '0;
    end else if (c1_wrap) begin
      c1 <= '0;
      c2 <= c2_wrap ? '0 : c2 + 1'b1;
    end else begin
      c1 <= c1 + 1'b1;
    end
  end

  // R2: the first stage never runs past M
  assert_stage1_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c1 <= m_act);

  // R3: the second stage never runs past its power-of-two limit
  assert_stage2_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c2 <= c2_lim);

  // R7: a cleared divider produces no tick and stays at zero
  assert_idle_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (c1 == '0 && c2 == '0));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int PHASES = 10,
  localparam int PH_W = $clog2(PHASES),
  localparam int HALF = PHASES / 2,
  localparam int SAMPLE_PH = HALF + HALF / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sub_tick,
  output logic scl_out,
  output logic rise_stb,
  output logic fall_stb,
  output logic sample_stb,
  output logic period_end
);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_next;

  assign period_end = sub_tick && (ph == PH_W'(PHASES - 1));
  assign ph_next    = period_end ? '0 : ph + 1'b1;
  assign scl_out    = (ph >= PH_W'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_W'(HALF);
      rise_stb   <= 1'b0;
      fall_stb   <= 1'b0;
      sample_stb <= 1'b0;
    end else if (clear) begin
      ph         <= PH_W'(HALF);
      rise_stb   <= 1'b0;
      fall_stb   <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      rise_stb   <= sub_tick && (ph_next == PH_W'(HALF));
      fall_stb   <= period_end;
      sample_stb <= sub_tick && (ph_next == PH_W'(SAMPLE_PH));
      if (sub_tick) ph <= ph_next;
    end
  end

  // R4: the phase index stays inside one period
  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ph < PH_W'(PHASES));

  // R4: a rise strobe sits on a fresh low-to-high SCL edge
  assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_out && !$past(scl_out)));

  // R4: a fall strobe sits on low SCL
  assert_fall_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !scl_out);

  // R5: sampling happens only while SCL is high
  assert_sample_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> scl_out);

  // R10: strobes never coincide
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb, sample_stb}));

  // R7: idle parks SCL high
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> scl_out);

endmodule

// File: rtl/i2c_rate_prescaler.sv
module i2c_rate_prescaler #(
  parameter int M_W = 4,
  parameter int N_W = 3,
  parameter int PHASES = 10,
  localparam int WORD_W = M_W + N_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              exp_mode,
  input  logic              run,
  output logic              sub_tick,
  output logic              scl_out,
  output logic              scl_rise,
  output logic              scl_fall,
  output logic              sample_pt
);

  logic [M_W-1:0] m_act;
  logic [N_W-1:0] n_act;
  logic           exp_act;
  logic           period_end;
  logic           clear;

  assign clear = soft_rst || !run;

  rate_cfg_reg #(.M_W(M_W), .N_W(N_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .exp_mode (exp_mode),
    .run      (run),
    .boundary (period_end),
    .m_act    (m_act),
    .n_act    (n_act),
    .exp_act  (exp_act)
  );

  rate_divider #(.M_W(M_W), .N_W(N_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .m_act    (m_act),
    .n_act    (n_act),
    .exp_act  (exp_act),
    .sub_tick (sub_tick)
  );

  scl_phase_seq #(.PHASES(PHASES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .sub_tick   (sub_tick),
    .scl_out    (scl_out),
    .rise_stb   (scl_rise),
    .fall_stb   (scl_fall),
    .sample_stb (sample_pt),
    .period_end (period_end)
  );

  // R7: nothing is emitted while idle
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(scl_rise || scl_fall || sample_pt));

endmodule

// File: tb/i2c_rate_prescaler_test.sv
module i2c_rate_prescaler_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       soft_rst = 0;
  logic       cfg_we = 0;
  logic [6:0] cfg_wdata = '0;
  logic       exp_mode = 0;
  logic       run = 0;
  logic       sub_tick, scl_out, scl_rise, scl_fall, sample_pt;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int overlap_viol = 0;
  int width_viol = 0;
  logic [2:0] prev_stb = '0;

  always #5 clk = ~clk;

  i2c_rate_prescaler uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .exp_mode(exp_mode), .run(run),
    .sub_tick(sub_tick), .scl_out(scl_out), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sample_pt(sample_pt)
  );

  // R10 monitor: strobe overlap and strobe width
  always @(negedge clk) begin
    if (rst_n) begin
      if ((32'(scl_rise) + 32'(scl_fall) + 32'(sample_pt)) > 1) overlap_viol++;
      if ((prev_stb & {scl_rise, scl_fall, sample_pt}) != 3'b000) width_viol++;
      prev_stb <= {scl_rise, scl_fall, sample_pt};
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // sub-tick length restated as a shift of the mantissa
  function automatic int ref_ticks(int m, int n, int short_exp);
    int sh = short_exp ? n : n + 1;
    return (m + 1) << sh;
  endfunction

  task automatic write_rate(int m, int n);
    @(negedge clk);
    cfg_we = 1;
    cfg_wdata = {4'(m), 3'(n)};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cycles_to_fall(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!scl_fall && cnt < 60000);
  endtask

  // from one fall to the next, noting rise and sample offsets
  task automatic measure_period(output int per, output int rise_at, output int samp_at);
    per = 0; rise_at = -1; samp_at = -1;
    do begin
      @(negedge clk);
      per++;
      if (scl_rise) rise_at = per;
      if (sample_pt) samp_at = per;
    end while (!scl_fall && per < 60000);
  endtask

  task automatic run_config(int m, int n, int short_exp);
    int p, first, per, ra, sa;
    p = ref_ticks(m, n, short_exp);
    @(negedge clk); run = 0;
    write_rate(m, n);
    exp_mode = short_exp[0];
    repeat (3) @(negedge clk);
    run = 1;
    cycles_to_fall(first);
    check("R7 first fall after run", first, 5 * p);
    measure_period(per, ra, sa);
    if (short_exp != 0) check("R3 period short exponent", per, 10 * p);
    else                check("R2 period normal exponent", per, 10 * p);
    check("R4 rise offset from fall", ra, 5 * p);
    check("R5 sample offset from fall", sa, 7 * p);
  endtask

  initial begin
    int per, ra, sa, first;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 scl high in reset", int'(scl_out), 1);
    check("R8 strobes low in reset", int'({scl_rise, scl_fall, sample_pt}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R8: fields at zero give a 2-cycle sub-tick
    run = 1;
    cycles_to_fall(first);
    check("R8 zero fields first fall", first, 10);
    run = 0;

    // R7 idle: high, quiet
    begin
      int bad = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!scl_out || scl_rise || scl_fall || sample_pt || sub_tick) bad++;
      end
      check("R7 idle quiet and high", bad, 0);
    end

    // R1..R5 sweep
    for (int sx = 0; sx < 2; sx++)
      for (int m = 0; m < 4; m++)
        for (int n = 0; n < 3; n++)
          run_config(m, n, sx);
    // widest field values, short exponent
    run_config(15, 7, 1);
    // R1: field placement, M=1 N=2 vs swapped reading differ
    run_config(1, 2, 0);

    // R6: change mid-run, old period finishes, new one follows
    run_config(1, 0, 0);
    @(negedge clk);
    cycles_to_fall(first);
    cfg_we = 1; cfg_wdata = {4'd3, 3'd1};
    measure_period(per, ra, sa);
    cfg_we = 0;
    check("R6 old period completes", per, 40);
    check("R6 old rise placement", ra, 20);
    measure_period(per, ra, sa);
    check("R6 new period applied", per, 10 * ref_ticks(3, 1, 0));
    // R6: exponent mode also waits for the boundary
    exp_mode = 1;
    measure_period(per, ra, sa);
    check("R6 mode change waits", per, 10 * ref_ticks(3, 1, 0));
    measure_period(per, ra, sa);
    check("R6 mode change applied", per, 10 * ref_ticks(3, 1, 1));

    // R9 soft reset clears settings
    run = 0; exp_mode = 0;
    write_rate(2, 1);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    check("R9 scl parked high", int'(scl_out), 1);
    run = 1;
    cycles_to_fall(first);
    check("R9 first fall with zero fields", first, 10);
    measure_period(per, ra, sa);
    check("R9 period with zero fields", per, 20);
    run = 0;

    check("R10 strobes never overlap", overlap_viol, 0);
    check("R10 strobes one cycle wide", width_viol, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule